// File: doc/BRIEF.md
# Prioritised Interrupt and Reset Sequencer

This block sits beside the fetch unit of a small processor core. It decides when the core must save its program counter and where it must load the next one from. Three sources can do this: leaving reset, an accepted interrupt request, and halt mode. Three active-low request lines are edge-detected, and each rising edge sets a per-source pending flag. A fixed-priority picker chooses among the pending flags, and a single state machine produces a push-PC strobe, a vector-fetch strobe with its address, a hold-PC (execute NOP) level and a one-hot acknowledge for the source being vectored.

Each request source owns a fixed vector word at the top of program memory. The lowest-numbered source sits at the very top. The reset vector sits directly below the last interrupt vector. Halt mode can be left only by an accepted interrupt. The PC is held during halt, so the pushed return address is the instruction after the halt, and execution resumes there once the core reports that the service routine has finished.

The state machine has eight states. `ST_RESET` is held while reset is low, and the first edge after release moves to `ST_BOOT_PUSH`. `ST_BOOT_PUSH` always moves on to `ST_BOOT_FETCH`, which always moves on to `ST_RUN`. `ST_RUN` goes to `ST_IRQ_PUSH` on accept, otherwise to `ST_HALT` if the halt input is high, otherwise it stays. `ST_HALT` goes to `ST_IRQ_PUSH` on accept and otherwise stays. `ST_IRQ_PUSH` always moves on to `ST_IRQ_FETCH`, which always moves on to `ST_SERVICE`. `ST_SERVICE` returns to `ST_RUN` when the service-done input is high. "Accept" means the global enable is high and at least one flag is pending.

Top module: `isr_seq_top`

## Requirements
- R1: A low-to-high transition of `irq_n[i]`, seen between two consecutive clock edges, sets pending flag i. A steady level or a falling transition sets nothing.
- R2: When several flags are pending, the lowest index is vectored first. The other flags stay pending and are vectored afterwards in index order.
- R3: During a vector fetch for source i, `vec_fetch` is 1, `vec_addr` is 0xFFF minus i (0xFFF, 0xFFE, 0xFFD), and `ack` is one-hot with bit i set. Outside a fetch, `ack` is 0 and `vec_addr` is 0.
- R4: Reset is asynchronous and active low. While it is low, `hold_pc` is 1 and `push_pc`, `vec_fetch` and `ack` are 0. All pending flags are cleared, so a request seen before reset is never vectored afterwards.
- R5: On the first edge after reset is released, `push_pc` is 1 for one cycle. The next cycle is a vector fetch at 0xFFC with `ack` 0. Normal running follows.
- R6: A high `halt_in` in the running state enters halt on the next edge. `hold_pc` then stays 1 every cycle, even after `halt_in` falls, until an interrupt is accepted.
- R7: No interrupt is accepted while `int_en` is 0. Pending flags are kept and are served once `int_en` rises, both while running and while halted.
- R8: An accepted interrupt gives exactly one cycle of `push_pc`, then exactly one cycle of vector fetch, then the service state. The served flag clears at the end of its fetch cycle.
- R9: In the service state no push or fetch occurs until `svc_done` is 1. The next cycle is normal running with `hold_pc` 0, including after a halt exit.
- R10: A new rising edge of a source during that source's own fetch cycle leaves its flag pending, so the source is vectored again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n | input | N_IRQ | Interrupt request lines, active low, rising edge registers a request |
| halt_in | input | 1 | Halt request, synchronous, sampled each rising edge |
| int_en | input | 1 | Global interrupt enable |
| svc_done | input | 1 | Core signals end of service routine |
| vec_fetch | output | 1 | Fetch new PC from `vec_addr` this cycle |
| vec_addr | output | ADDR_W | Vector location being fetched |
| push_pc | output | 1 | Push current PC onto the stack this cycle |
| hold_pc | output | 1 | Keep PC unchanged and execute NOP |
| ack | output | N_IRQ | One-hot acknowledge of the source being vectored |

## Verification
The assertions take the request lines, `halt_in`, `int_en` and `svc_done` to be synchronous to the clock and free of glitches within a cycle. They also take `svc_done` to be meaningful only in the service state. The stimulus changes every input on the falling clock edge and raises `svc_done` only after a fetch has been observed. Reset is the one input driven off-grid, and it is dropped mid-cycle to exercise its asynchronous path.

// File: rtl/isr_seq_pkg.sv
package isr_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET      = 3'd0,
        ST_BOOT_PUSH  = 3'd1,
        ST_BOOT_FETCH = 3'd2,
        ST_RUN        = 3'd3,
        ST_HALT       = 3'd4,
        ST_IRQ_PUSH   = 3'd5,
        ST_IRQ_FETCH  = 3'd6,
        ST_SERVICE    = 3'd7
    } seq_state_e;

endpackage

// File: rtl/isr_edge_pending.sv
module isr_edge_pending #(
    parameter int N_IRQ = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_n,
    input  logic [N_IRQ-1:0] clr,
    output logic [N_IRQ-1:0] pend
);

    logic [N_IRQ-1:0] prev_q;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_src
        // a fresh edge outranks a same-cycle clear (R10)
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b1;
                pend[g]   <= 1'b0;
            end else begin
                prev_q[g] <= irq_n[g];
                if (irq_n[g] && !prev_q[g]) begin
                    pend[g] <= 1'b1;
                end else if (clr[g]) begin
                    pend[g] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/isr_prio_pick.sv
module isr_prio_pick #(
    parameter int N_IRQ = 3,
    localparam int SEL_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic [N_IRQ-1:0] pend,
    output logic             any,
    output logic [SEL_W-1:0] idx
);

    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/isr_seq_fsm.sv
module isr_seq_fsm
    import isr_seq_pkg::*;
#(
    parameter int N_IRQ  = 3,
    parameter int ADDR_W = 12,
    localparam int SEL_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_in,
    input  logic              int_en,
    input  logic              svc_done,
    input  logic              req_any,
    input  logic [SEL_W-1:0]  req_idx,
    output seq_state_e        state,
    output logic              vec_fetch,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              push_pc,
    output logic              hold_pc,
    output logic [N_IRQ-1:0]  ack
);

    localparam logic [ADDR_W-1:0] VEC_TOP  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOOT_VEC = VEC_TOP - ADDR_W'(N_IRQ);

    seq_state_e       state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic             accept;
    logic             take;

    assign accept = int_en && req_any;
    assign take   = accept && (state_q == ST_RUN || state_q == ST_HALT);
    assign state  = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:      state_d = ST_BOOT_PUSH;
            ST_BOOT_PUSH:  state_d = ST_BOOT_FETCH;
            ST_BOOT_FETCH: state_d = ST_RUN;
            ST_RUN: begin
                if (accept) begin
                    state_d = ST_IRQ_PUSH;
                end else if (halt_in) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (accept) begin
                    state_d = ST_IRQ_PUSH;
                end
            end
            ST_IRQ_PUSH:   state_d = ST_IRQ_FETCH;
            ST_IRQ_FETCH:  state_d = ST_SERVICE;
            ST_SERVICE: begin
                if (svc_done) begin
                    state_d = ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (take) begin
            sel_q <= req_idx;
        end
    end

    always_comb begin
        vec_fetch = 1'b0;
        vec_addr  = '0;
        push_pc   = 1'b0;
        hold_pc   = 1'b0;
        ack       = '0;
        unique case (state_q)
            ST_RESET:      hold_pc = 1'b1;
            ST_BOOT_PUSH:  push_pc = 1'b1;
            ST_BOOT_FETCH: begin
                vec_fetch = 1'b1;
                vec_addr  = BOOT_VEC;
            end
            ST_RUN:        hold_pc = 1'b0;
            ST_HALT:       hold_pc = 1'b1;
            ST_IRQ_PUSH:   push_pc = 1'b1;
            ST_IRQ_FETCH: begin
                vec_fetch = 1'b1;
                vec_addr  = VEC_TOP - ADDR_W'(sel_q);
                ack       = N_IRQ'(1) << sel_q;
            end
            ST_SERVICE:    hold_pc = 1'b0;
        endcase
    end

endmodule

// File: rtl/isr_seq_top.sv
module isr_seq_top
    import isr_seq_pkg::*;
#(
    parameter int N_IRQ  = 3,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_n,
    input  logic              halt_in,
    input  logic              int_en,
    input  logic              svc_done,
    output logic              vec_fetch,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              push_pc,
    output logic              hold_pc,
    output logic [N_IRQ-1:0]  ack
);

    localparam int SEL_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    logic [N_IRQ-1:0] pend;
    logic             req_any;
    logic [SEL_W-1:0] req_idx;
    seq_state_e       fsm_state;

    isr_edge_pending #(.N_IRQ(N_IRQ)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_n (irq_n),
        .clr   (ack),
        .pend  (pend)
    );

    isr_prio_pick #(.N_IRQ(N_IRQ)) u_pick (
        .pend (pend),
        .any  (req_any),
        .idx  (req_idx)
    );

    isr_seq_fsm #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_in   (halt_in),
        .int_en    (int_en),
        .svc_done  (svc_done),
        .req_any   (req_any),
        .req_idx   (req_idx),
        .state     (fsm_state),
        .vec_fetch (vec_fetch),
        .vec_addr  (vec_addr),
        .push_pc   (push_pc),
        .hold_pc   (hold_pc),
        .ack       (ack)
    );

endmodule

// File: rtl/isr_seq_chk.sv
module isr_seq_chk
    import isr_seq_pkg::*;
#(
    parameter int N_IRQ  = 3,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_en,
    input logic              svc_done,
    input logic              vec_fetch,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              push_pc,
    input logic              hold_pc,
    input logic [N_IRQ-1:0]  ack,
    input seq_state_e        state
);

    localparam logic [ADDR_W-1:0] VEC_TOP  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOOT_VEC = VEC_TOP - ADDR_W'(N_IRQ);

    assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));

    assert_ack_in_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |-> vec_fetch);

    for (genvar g = 0; g < N_IRQ; g++) begin : g_vec
        localparam logic [ADDR_W-1:0] VEXP = VEC_TOP - ADDR_W'(g);
        assert_ack_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ack[g] |-> (vec_addr == VEXP));
    end

    assert_boot_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT_PUSH) |=> (vec_fetch && vec_addr == BOOT_VEC && ack == '0));

    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !int_en) |=> (state == ST_HALT && hold_pc));

    assert_mask_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !int_en) |=> !push_pc);

    assert_push_then_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_pc |=> (vec_fetch && !push_pc));

    assert_push_fetch_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_pc |-> !vec_fetch);

    assert_service_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVICE && !svc_done) |=> (state == ST_SERVICE && !push_pc && !vec_fetch));

    assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVICE && svc_done) |=> (state == ST_RUN && !hold_pc));

endmodule

bind isr_seq_top isr_seq_chk #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_en    (int_en),
    .svc_done  (svc_done),
    .vec_fetch (vec_fetch),
    .vec_addr  (vec_addr),
    .push_pc   (push_pc),
    .hold_pc   (hold_pc),
    .ack       (ack),
    .state     (fsm_state)
);

// File: tb/tb_isr_seq_top.sv
`timescale 1ns/1ps
module tb_isr_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  irq_n = 3'b111;
    logic        halt_in = 1'b0;
    logic        int_en = 1'b0;
    logic        svc_done = 1'b0;
    logic        vec_fetch;
    logic [11:0] vec_addr;
    logic        push_pc;
    logic        hold_pc;
    logic [2:0]  ack;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    isr_seq_top dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .halt_in(halt_in),
        .int_en(int_en), .svc_done(svc_done), .vec_fetch(vec_fetch),
        .vec_addr(vec_addr), .push_pc(push_pc), .hold_pc(hold_pc), .ack(ack)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 rst,1 bpush,2 bfetch,3 run,4 halt,5 ipush,6 ifetch,7 svc
    int         m_st = 0;
    int         m_sel = 0;
    logic [2:0] m_pend = 3'b000;
    logic [2:0] m_prev = 3'b111;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_sel = 0; m_pend = 3'b000; m_prev = 3'b111;
        end else begin
            logic [2:0] edges;
            logic [2:0] nxt_pend;
            bit         go;
            int         nxt;
            edges = irq_n & ~m_prev;
            go = int_en && (m_pend != 3'b000) && (m_st == 3 || m_st == 4);
            nxt = m_st;
            if (m_st == 0) nxt = 1;
            else if (m_st == 1) nxt = 2;
            else if (m_st == 2) nxt = 3;
            else if (m_st == 3) nxt = go ? 5 : (halt_in ? 4 : 3);
            else if (m_st == 4) nxt = go ? 5 : 4;
            else if (m_st == 5) nxt = 6;
            else if (m_st == 6) nxt = 7;
            else if (svc_done) nxt = 3;
            nxt_pend = m_pend;
            if (m_st == 6) nxt_pend[m_sel] = 1'b0;
            nxt_pend = nxt_pend | edges;
            if (go) m_sel = m_pend[0] ? 0 : (m_pend[1] ? 1 : 2);
            m_pend = nxt_pend;
            m_prev = irq_n;
            m_st = nxt;
        end
    end

    always @(posedge clk) begin
        #5;
        if (!done && rst_n) begin
            logic [11:0] e_addr;
            e_addr = (m_st == 2) ? 12'hFFC : ((m_st == 6) ? 12'hFFF - 12'(m_sel) : 12'h000);
            check("R3 model vec_fetch", 32'(vec_fetch), 32'(m_st == 2 || m_st == 6));
            check("R3 model vec_addr", 32'(vec_addr), 32'(e_addr));
            check("R8 model push_pc", 32'(push_pc), 32'(m_st == 1 || m_st == 5));
            check("R6 model hold_pc", 32'(hold_pc), 32'(m_st == 0 || m_st == 4));
            check("R2 model ack", 32'(ack), (m_st == 6) ? (32'd1 << m_sel) : 32'd0);
        end
    end

    task automatic summary();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
            summary();
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edge_on(int i);
        irq_n[i] = 1'b0; tick(1);
        irq_n[i] = 1'b1; tick(1);
    endtask

    task automatic wait_fetch(string tag);
        bit seen;
        seen = 1'b0;
        for (int k = 0; k < 12 && !seen; k++) begin
            tick(1);
            if (vec_fetch) seen = 1'b1;
        end
        check({tag, " fetch seen"}, 32'(seen), 32'd1);
    endtask

    task automatic end_service();
        tick(2);
        svc_done = 1'b1; tick(1);
        svc_done = 1'b0;
    endtask

    task automatic serve(logic [11:0] exp_addr, logic [2:0] exp_ack, string tag);
        wait_fetch(tag);
        check({tag, " vec_addr"}, 32'(vec_addr), 32'(exp_addr));
        check({tag, " ack"}, 32'(ack), 32'(exp_ack));
        end_service();
    endtask

    initial begin
        tick(3);
        // R4: held in reset
        check("R4 hold_pc in reset", 32'(hold_pc), 32'd1);
        check("R4 push_pc in reset", 32'(push_pc), 32'd0);
        check("R4 vec_fetch in reset", 32'(vec_fetch), 32'd0);
        rst_n = 1'b1;
        tick(1);
        check("R5 boot push", 32'(push_pc), 32'd1);
        tick(1);
        check("R5 boot fetch", 32'(vec_fetch), 32'd1);
        check("R5 boot vector", 32'(vec_addr), 32'hFFC);
        check("R5 boot ack", 32'(ack), 32'd0);
        tick(1);
        check("R5 running", 32'(vec_fetch | push_pc | hold_pc), 32'd0);

        // R1: falling edge and low level do nothing
        int_en = 1'b1;
        irq_n[1] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick(1);
            check("R1 no request on fall", 32'(push_pc | vec_fetch), 32'd0);
        end
        irq_n[1] = 1'b1;
        serve(12'hFFE, 3'b010, "R1");

        // R7 and R2: simultaneous edges, masked then served in order
        int_en = 1'b0;
        irq_n = 3'b000; tick(1);
        irq_n = 3'b111;
        for (int k = 0; k < 4; k++) begin
            tick(1);
            check("R7 masked", 32'(push_pc | vec_fetch), 32'd0);
        end
        int_en = 1'b1;
        serve(12'hFFF, 3'b001, "R2 first");
        serve(12'hFFE, 3'b010, "R2 second");
        serve(12'hFFD, 3'b100, "R2 third");

        // R6: halt persists after halt_in drops
        halt_in = 1'b1; tick(1);
        halt_in = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick(1);
            check("R6 halted", 32'(hold_pc), 32'd1);
        end
        edge_on(2);
        serve(12'hFFD, 3'b100, "R6 exit");
        tick(1);
        check("R9 resumed", 32'(hold_pc), 32'd0);

        // R7 while halted
        int_en = 1'b0;
        halt_in = 1'b1; tick(1);
        halt_in = 1'b0;
        edge_on(1);
        for (int k = 0; k < 3; k++) begin
            tick(1);
            check("R7 halted masked", 32'(hold_pc), 32'd1);
        end
        int_en = 1'b1;
        serve(12'hFFE, 3'b010, "R7 halt release");

        // R9: service blocks new fetches until done
        edge_on(0);
        wait_fetch("R9");
        edge_on(1);
        for (int k = 0; k < 3; k++) begin
            tick(1);
            check("R9 blocked in service", 32'(push_pc | vec_fetch), 32'd0);
        end
        svc_done = 1'b1; tick(1);
        svc_done = 1'b0;
        serve(12'hFFE, 3'b010, "R9 after done");

        // R10: re-edge during own fetch cycle
        edge_on(0);
        irq_n[0] = 1'b0;
        wait_fetch("R10 first");
        irq_n[0] = 1'b1;
        end_service();
        serve(12'hFFF, 3'b001, "R10 again");

        // R4: asynchronous reset clears pending
        int_en = 1'b0;
        edge_on(2);
        #3 rst_n = 1'b0;
        #1;
        check("R4 async hold", 32'(hold_pc), 32'd1);
        check("R4 async push", 32'(push_pc | vec_fetch), 32'd0);
        check("R4 async ack", 32'(ack), 32'd0);
        tick(2);
        rst_n = 1'b1;
        tick(3);
        int_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            tick(1);
            check("R4 pending cleared", 32'(vec_fetch | push_pc), 32'd0);
        end
        summary();
    end

endmodule